// File: doc/BRIEF.md
# Edge Time Capture Unit

This block timestamps transitions on two external signals against a 16-bit up-counter that advances once per clock. Each signal is synchronised and split into rising and falling events, and each event type of each channel has its own 8-bit result register. Four result registers exist in total. In the normal 8-bit mode a result is an 8-bit slice of the counter; a configurable shift picks the slice, which trades resolution for range. A mode bit fuses the two channels into one 16-bit capture driven by channel 0 alone. Channel 1's two registers then carry the upper byte, and channel 0's two registers carry the lower byte.

Software reaches the unit through a simple single-cycle read/write bus. The counter is two bytes wide, so reading it is a two-step sequence: a low-byte read freezes a copy of the upper byte for the next read. Writing it is also two steps: a low-byte write is held back until the high-byte write commits both bytes together. A hold option freezes each result register at its first event until software reads that register. Each result register has an interrupt-enable bit and a pulsed request output.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset the counter is 0 and it increases by one on every clock, wrapping from 0xFFFF to 0x0000, except on a cycle that writes the high byte.
- R2: A write to address 0 stores the byte in a holding buffer and leaves the counter unchanged. A write to address 1 loads the counter with {written byte, buffered byte}, and the counter keeps counting up from that value on the following clocks.
- R3: A read of address 0 returns the live counter low byte and, on that clock, copies the counter high byte into a shadow register. Address 1 always returns the shadow register.
- R4: Address 2 is the configuration register, 0 after reset: bit 7 is hold, bits 6:4 are the shift N, bit 3 is the 16-bit merge, and bits 2:0 read as 0. Address 3 holds the four interrupt enables in bits 3:0, and its bits 7:4 read as 0.
- R5: Addresses 4, 5, 6 and 7 return channel 0 rise, channel 0 fall, channel 1 rise and channel 1 fall. In 8-bit mode a load stores counter bits [N+7:N].
- R6: Each input passes two synchronising flops. An input change that is first sampled at clock edge k is detected in the cycle after edge k+1. The stored value is the counter value of that cycle, and it is visible after edge k+2.
- R7: With hold clear, every matching edge reloads its register, so the register shows the most recent edge.
- R8: With hold set, a register that has loaded ignores later edges until software reads it. If a read and an edge fall in the same cycle on an unlocked register, the load happens and the register stays locked. On a locked register the edge is lost and the lock is released. Clearing hold releases every lock.
- R9: With merge set, a channel 0 edge loads counter[7:0] into its low register (4 or 5) and counter[15:8] into the matching high register (6 or 7) on the same clock. The shift N is not applied, and channel 1 edges change nothing.
- R10: With merge and hold both set, a loaded pair stays frozen until its high register (6 or 7) is read. Reading only the low register does not release it.
- R11: cap_irq[k] is high for exactly the one cycle in which register 4+k first shows a newly loaded value, and only if enable bit k is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_in | input | 2 | Asynchronous capture inputs, bit 0 channel 0, bit 1 channel 1 |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; side effects occur on that clock |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| cap_irq | output | 4 | Interrupt request pulses, bit k for register 4+k |

## Verification
The interaction that needs care is a software read of a result register arriving in the same cycle as a new edge for that register while hold is set. One path releases the lock and the other loads a value and sets the lock, so the ordering decides what software sees next. The bench provokes the collision by raising a capture pin and then issuing the read after a delay that it sweeps over several cycles, so that one of the sweeps lands exactly on the detection cycle. A behavioural model running in parallel predicts bus_rdata and cap_irq on every clock, and any divergence in the register value, the lock or the interrupt is reported.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  localparam int CAP_W  = 8;
  localparam int TMR_W  = 2 * CAP_W;
  localparam int PS_W   = $clog2(CAP_W);
  localparam int NCH    = 2;
  localparam int NREG   = 2 * NCH;

  localparam int A_TLO  = 0;
  localparam int A_THI  = 1;
  localparam int A_CFG  = 2;
  localparam int A_IEN  = 3;
  localparam int A_CAP0 = 4;
endpackage

// File: rtl/ecu_timer.sv
module ecu_timer
  import ecu_pkg::*;
(
  input  logic             clk,
  input  logic             arst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             rd_lo,
  input  logic [CAP_W-1:0] wdata,
  output logic [TMR_W-1:0] count_o,
  output logic [CAP_W-1:0] shadow_o
);
  logic [TMR_W-1:0] count_q, count_d;
  logic [CAP_W-1:0] lobuf_q, lobuf_d;
  logic [CAP_W-1:0] shadow_q, shadow_d;

  always_comb begin
    count_d  = wr_hi ? {wdata, lobuf_q} : count_q + TMR_W'(1);
    lobuf_d  = wr_lo ? wdata : lobuf_q;
    shadow_d = rd_lo ? count_q[TMR_W-1:CAP_W] : shadow_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      count_q  <= '0;
      lobuf_q  <= '0;
      shadow_q <= '0;
    end else begin
      count_q  <= count_d;
      lobuf_q  <= lobuf_d;
      shadow_q <= shadow_d;
    end
  end

  assign count_o  = count_q;
  assign shadow_o = shadow_q;

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!arst_n)
    !wr_hi |=> count_q == TMR_W'($past(count_q) + TMR_W'(1))); // R1

  AST_SHADOW_KEEP: assert property (@(posedge clk) disable iff (!arst_n)
    !rd_lo |=> $stable(shadow_q)); // R3
endmodule

// File: rtl/ecu_edge_sync.sv
module ecu_edge_sync (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~prev_q;
  assign fall_o = ~s2_q & prev_q;

  AST_SYNC_RISE: assert property (@(posedge clk) disable iff (!arst_n)
    rise_o |-> $past(pin_i, 2)); // R6

  AST_SYNC_FALL: assert property (@(posedge clk) disable iff (!arst_n)
    fall_o |-> !$past(pin_i, 2)); // R6
endmodule

// File: rtl/ecu_capture.sv
module ecu_capture
  import ecu_pkg::*;
(
  input  logic                       clk,
  input  logic                       arst_n,
  input  logic [NCH-1:0]             rise_i,
  input  logic [NCH-1:0]             fall_i,
  input  logic [TMR_W-1:0]           count_i,
  input  logic [PS_W-1:0]            shift_i,
  input  logic                       hold_i,
  input  logic                       wide_i,
  input  logic [NREG-1:0]            ien_i,
  input  logic [NREG-1:0]            rd_i,
  output logic [NREG-1:0][CAP_W-1:0] cap_o,
  output logic [NREG-1:0]            irq_o
);
  logic [NREG-1:0][CAP_W-1:0] cap_q, cap_d, val;
  logic [NREG-1:0]            lock_q, lock_d;
  logic [NREG-1:0]            irq_q, irq_d;
  logic [NREG-1:0]            hit, gate, ld;
  logic [TMR_W-1:0]           shifted;
  logic [CAP_W-1:0]           win;

  always_comb begin
    shifted = count_i >> shift_i;
    win     = shifted[CAP_W-1:0];
    hit[0]  = rise_i[0];
    hit[1]  = fall_i[0];
    hit[2]  = wide_i ? rise_i[0] : rise_i[1];
    hit[3]  = wide_i ? fall_i[0] : fall_i[1];
    for (int k = 0; k < NREG; k++) begin
      gate[k]   = wide_i ? lock_q[k | 2] : lock_q[k];
      ld[k]     = hit[k] & ~(hold_i & gate[k]);
      if (wide_i)
        val[k] = (k >= 2) ? count_i[TMR_W-1:CAP_W] : count_i[CAP_W-1:0];
      else
        val[k] = win;
      cap_d[k]  = ld[k] ? val[k] : cap_q[k];
      lock_d[k] = hold_i & (ld[k] | (lock_q[k] & ~rd_i[k]));
      irq_d[k]  = ld[k] & ien_i[k];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cap_q  <= '0;
      lock_q <= '0;
      irq_q  <= '0;
    end else begin
      cap_q  <= cap_d;
      lock_q <= lock_d;
      irq_q  <= irq_d;
    end
  end

  assign cap_o = cap_q;
  assign irq_o = irq_q;

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!arst_n)
      hold_i && gate[g] |=> $stable(cap_q[g])); // R8
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!arst_n)
      irq_q[g] |=> !irq_q[g]); // R11
  end

  AST_WIDE_IGNORE_RISE: assert property (@(posedge clk) disable iff (!arst_n)
    wide_i && rise_i[1] && !rise_i[0] |=> $stable(cap_q[2])); // R9

  AST_WIDE_IGNORE_FALL: assert property (@(posedge clk) disable iff (!arst_n)
    wide_i && fall_i[1] && !fall_i[0] |=> $stable(cap_q[3])); // R9
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecu_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cap_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CAP_W-1:0]  bus_wdata,
  output logic [CAP_W-1:0]  bus_rdata,
  output logic [NREG-1:0]   cap_irq
);
  logic [1:0]                 rs_q;
  logic                       arst_n;
  logic                       hold_q, hold_d, wide_q, wide_d;
  logic [PS_W-1:0]            ps_q, ps_d;
  logic [NREG-1:0]            ien_q, ien_d;
  logic                       wr_tlo, wr_thi, wr_cfg, wr_ien, rd_tlo;
  logic [NREG-1:0]            cap_rd;
  logic [NCH-1:0]             rise, fall;
  logic [TMR_W-1:0]           count;
  logic [CAP_W-1:0]           shadow;
  logic [NREG-1:0][CAP_W-1:0] cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n = rs_q[1];

  always_comb begin
    wr_tlo = bus_wr && (bus_addr == ADDR_W'(A_TLO));
    wr_thi = bus_wr && (bus_addr == ADDR_W'(A_THI));
    wr_cfg = bus_wr && (bus_addr == ADDR_W'(A_CFG));
    wr_ien = bus_wr && (bus_addr == ADDR_W'(A_IEN));
    rd_tlo = bus_rd && (bus_addr == ADDR_W'(A_TLO));
    for (int k = 0; k < NREG; k++)
      cap_rd[k] = bus_rd && (bus_addr == ADDR_W'(A_CAP0 + k));
  end

  always_comb begin
    hold_d = wr_cfg ? bus_wdata[7]          : hold_q;
    ps_d   = wr_cfg ? bus_wdata[6:4]        : ps_q;
    wide_d = wr_cfg ? bus_wdata[3]          : wide_q;
    ien_d  = wr_ien ? bus_wdata[NREG-1:0]   : ien_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hold_q <= 1'b0;
      ps_q   <= '0;
      wide_q <= 1'b0;
      ien_q  <= '0;
    end else begin
      hold_q <= hold_d;
      ps_q   <= ps_d;
      wide_q <= wide_d;
      ien_q  <= ien_d;
    end
  end

  ecu_timer u_timer (
    .clk      (clk),
    .arst_n   (arst_n),
    .wr_lo    (wr_tlo),
    .wr_hi    (wr_thi),
    .rd_lo    (rd_tlo),
    .wdata    (bus_wdata),
    .count_o  (count),
    .shadow_o (shadow)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_sync
    ecu_edge_sync u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .pin_i  (cap_in[c]),
      .rise_o (rise[c]),
      .fall_o (fall[c])
    );
  end

  ecu_capture u_cap (
    .clk     (clk),
    .arst_n  (arst_n),
    .rise_i  (rise),
    .fall_i  (fall),
    .count_i (count),
    .shift_i (ps_q),
    .hold_i  (hold_q),
    .wide_i  (wide_q),
    .ien_i   (ien_q),
    .rd_i    (cap_rd),
    .cap_o   (cap),
    .irq_o   (cap_irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_TLO)) bus_rdata = count[CAP_W-1:0];
    if (bus_addr == ADDR_W'(A_THI)) bus_rdata = shadow;
    if (bus_addr == ADDR_W'(A_CFG)) bus_rdata = {hold_q, ps_q, wide_q, 3'b000};
    if (bus_addr == ADDR_W'(A_IEN)) bus_rdata = {{(CAP_W-NREG){1'b0}}, ien_q};
    for (int k = 0; k < NREG; k++)
      if (bus_addr == ADDR_W'(A_CAP0 + k)) bus_rdata = cap[k];
  end

  AST_CFG_LOW_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
    (bus_addr == ADDR_W'(A_CFG)) |-> bus_rdata[2:0] == 3'b000); // R4
endmodule

// File: tb/edge_capture_unit_tb_top.sv
module edge_capture_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cap_in;
  logic       bus_wr, bus_rd;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [3:0] cap_irq;

  int    errors = 0;
  int    checks = 0;
  int    cyc = 0;
  string ph = "R1";

  always #10 clk = ~clk;

  edge_capture_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_irq(cap_irq)
  );

  // behavioural reference model
  int mt, mbuf, msh, mhold, mps, mwide, mien;
  int mcap [4];
  bit mlock [4];
  bit mirq [4];
  bit ms1 [2], ms2 [2], mpv [2];
  bit mr1, mr2;

  always @(posedge clk or negedge rst_n) begin
    bit rs [2], fl [2], hit, ld [4], rdk;
    int v [4], c, key;
    if (!rst_n) begin
      mt = 0; mbuf = 0; msh = 0; mhold = 0; mps = 0; mwide = 0; mien = 0;
      for (int k = 0; k < 4; k++) begin mcap[k] = 0; mlock[k] = 0; mirq[k] = 0; end
      for (int j = 0; j < 2; j++) begin ms1[j] = 0; ms2[j] = 0; mpv[j] = 0; end
      mr1 = 0; mr2 = 0;
    end else begin
      if (mr2) begin
        for (int j = 0; j < 2; j++) begin
          rs[j] = ms2[j] && !mpv[j];
          fl[j] = !ms2[j] && mpv[j];
        end
        for (int k = 0; k < 4; k++) begin
          c     = (mwide != 0) ? 0 : k / 2;
          hit   = (k % 2 == 0) ? rs[c] : fl[c];
          key   = (mwide != 0) ? (k | 2) : k;
          ld[k] = hit && !((mhold != 0) && mlock[key]);
          if (mwide != 0) v[k] = (k >= 2) ? (mt >> 8) & 255 : mt & 255;
          else            v[k] = (mt >> mps) & 255;
        end
        for (int k = 0; k < 4; k++) begin
          rdk     = bus_rd && (bus_addr == 4 + k);
          mirq[k] = ld[k] && (((mien >> k) & 1) != 0);
          if (ld[k]) mcap[k] = v[k];
          if (mhold == 0)  mlock[k] = 0;
          else if (ld[k])  mlock[k] = 1;
          else if (rdk)    mlock[k] = 0;
        end
        if (bus_rd && bus_addr == 0) msh = (mt >> 8) & 255;
        if (bus_wr && bus_addr == 1) mt = (bus_wdata << 8) | mbuf;
        else                         mt = (mt + 1) & 16'hFFFF;
        if (bus_wr && bus_addr == 0) mbuf = bus_wdata;
        if (bus_wr && bus_addr == 2) begin
          mhold = bus_wdata[7]; mps = (bus_wdata >> 4) & 7; mwide = bus_wdata[3];
        end
        if (bus_wr && bus_addr == 3) mien = bus_wdata & 15;
        for (int j = 0; j < 2; j++) begin
          mpv[j] = ms2[j]; ms2[j] = ms1[j]; ms1[j] = cap_in[j];
        end
      end
      mr2 = mr1; mr1 = 1;
    end
  end

  function automatic int exp_rdata(int a);
    case (a)
      0: return mt & 255;
      1: return msh;
      2: return (mhold << 7) | (mps << 4) | (mwide << 3);
      3: return mien;
      4, 5, 6, 7: return mcap[a - 4];
      default: return 0;
    endcase
  endfunction

  function automatic int exp_irq();
    return {28'd0, mirq[3], mirq[2], mirq[1], mirq[0]};
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h t=%0t", tag, bus_addr, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(ph, int'(bus_rdata), exp_rdata(int'(bus_addr)));
      check("R11", int'(cap_irq), exp_irq());
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      finish_run();
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr_t(int a, int d);
    step(); bus_wr = 1; bus_addr = 4'(a); bus_wdata = 8'(d);
    step(); bus_wr = 0;
  endtask

  task automatic rd_t(int a);
    step(); bus_rd = 1; bus_addr = 4'(a);
    step(); bus_rd = 0;
  endtask

  task automatic look(int a);
    bus_addr = 4'(a);
  endtask

  task automatic pulse(int ch, int n);
    step(); cap_in[ch] = 1'b1;
    repeat (n) step();
    cap_in[ch] = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  initial begin
    rst_n = 1'b0; cap_in = 2'b00; bus_wr = 0; bus_rd = 0;
    bus_addr = 4'd2; bus_wdata = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4", int'(bus_rdata), 0);
    check("R11", int'(cap_irq), 0);
    bus_addr = 4'd0;
    #1 check("R1", int'(bus_rdata), 0);
    step(); rst_n = 1'b1;

    ph = "R1"; look(0); idle(20);

    ph = "R3"; rd_t(0); look(1); idle(5); rd_t(0); look(1); idle(3);

    ph = "R2"; wr_t(0, 8'hF0); look(0); idle(3); wr_t(1, 8'hFF); idle(3);
    rd_t(0); look(1); step(); look(0);
    ph = "R1"; idle(30); rd_t(0); look(1); step();

    ph = "R4"; wr_t(2, 8'hFF); look(2); step(); wr_t(3, 8'hFF); look(3); step();
    wr_t(2, 8'h00); look(2); step();

    ph = "R5"; wr_t(2, 8'h30); look(4); pulse(0, 5); idle(6); look(5); idle(2);
    pulse(1, 3); idle(5); look(6); step(); look(7); step();

    ph = "R6"; wr_t(2, 8'h00); look(4);
    for (int n = 0; n < 4; n++) begin pulse(0, 1); idle(n + 2); end
    look(5); idle(3);

    ph = "R7"; wr_t(2, 8'h70); look(4);
    for (int i = 0; i < 5; i++) begin pulse(0, 2); idle(2); end
    idle(5); look(5); idle(2);

    ph = "R8"; wr_t(2, 8'h80); look(4); pulse(0, 3); idle(8); pulse(0, 3); idle(8);
    rd_t(4); idle(2);
    for (int off = 0; off < 6; off++) begin
      step(); cap_in[0] = 1'b1;
      idle(off);
      rd_t(4);
      cap_in[0] = 1'b0; idle(6);
    end
    look(5); rd_t(5); idle(3); wr_t(2, 8'h00); look(4); pulse(0, 3); idle(6);

    ph = "R9"; wr_t(2, 8'h58); look(4); pulse(0, 4); idle(6); look(6); step();
    look(5); step(); look(7); step();
    pulse(1, 4); idle(6); look(6); step(); look(7); step();

    ph = "R10"; wr_t(2, 8'h88); look(4); pulse(0, 3); idle(6); pulse(0, 3); idle(6);
    rd_t(4); pulse(0, 3); idle(6); look(6);
    rd_t(6); pulse(0, 3); idle(6); look(4); step(); look(6); step();

    ph = "R11"; wr_t(2, 8'h00); wr_t(3, 8'h05); look(4);
    pulse(0, 3); pulse(1, 3); idle(6);
    wr_t(3, 8'h00); pulse(0, 3); pulse(1, 3); idle(6);

    finish_run();
  end
endmodule